// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences a chip between three operating conditions: full activity, a light sleep in which only the processor clock stops, and a deep sleep in which every clock stops, the internal oscillator is switched off, the flash goes to standby and the analog blocks lose power. The exception is analog blocks chosen as wake sources, which stay powered. The block drives all of these gating and power enables from one enumerated state machine. Register and memory contents survive both low-power conditions, so the controller never issues any state-clearing reset.

Software asks for entry with a one-cycle request and a mode select. The peripheral clock-keep mask and the analog keep-alive mask are captured at that moment. An interrupt ends either low-power condition. From light sleep the block returns at once. From deep sleep it turns the oscillator back on first and waits a settle count that software sets. It then ungates the main clock and takes the flash out of standby. The processor clock comes back only after the flash reports ready. A reset returns the block to full activity at any time.

States and transitions: `ST_ACTIVE` goes to `ST_SLEEP` or `ST_DEEP` on an accepted request. `ST_SLEEP` goes to `ST_ACTIVE` on an interrupt. `ST_DEEP` goes to `ST_OSC_WAIT` on an interrupt. `ST_OSC_WAIT` goes to `ST_FLASH_WAIT` when the settle timer expires. `ST_FLASH_WAIT` goes to `ST_ACTIVE` on flash ready. Reset leads from every state to `ST_ACTIVE`.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the active state, every clock enable is 1, `osc_en` is 1, `flash_stby` is 0, every analog power enable is 1 and `cur_mode` is 2'b00. A reset asserted during deep sleep restores this at once.
- R2: In the active state, `enter_req` high with `irq_pending` low moves the block to light sleep (`cur_mode` 2'b01) when `req_deep` is 0, or to deep sleep (`cur_mode` 2'b10) when `req_deep` is 1, one cycle later.
- R3: In light sleep, `cpu_clk_en` is 0 and `main_clk_en` is 1. `periph_clk_en` equals the `periph_keep` value captured at entry. `osc_en` is 1, `flash_stby` is 0 and all analog enables are 1.
- R4: In deep sleep, `cpu_clk_en`, `main_clk_en` and every bit of `periph_clk_en` are 0, whatever `periph_keep` was. `osc_en` is 0 and `flash_stby` is 1.
- R5: In deep sleep and throughout the wake sequence that follows, `analog_pwr_en` equals the `analog_keep` value captured at entry.
- R6: In light sleep, `irq_pending` high returns the block to the active state one cycle later.
- R7: In deep sleep, `irq_pending` high raises `osc_en` one cycle later, while `main_clk_en` stays 0 (`cur_mode` 2'b11). `main_clk_en` rises exactly `osc_settle`+1 cycles after `osc_en` rises, and `flash_stby` falls in that same cycle. `osc_settle` is sampled when the interrupt is taken.
- R8: After the main clock is ungated, `cpu_clk_en` stays 0 while `flash_ready` is low. It rises one cycle after `flash_ready` is sampled high, and `cur_mode` then returns to 2'b00.
- R9: An `enter_req` made while `irq_pending` is high is ignored, and the block stays in the active state with all clocks on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to enter a low-power state |
| req_deep | input | 1 | 1 selects deep sleep, 0 selects light sleep |
| periph_keep | input | NUM_PERIPH | Peripherals whose clock runs in light sleep |
| analog_keep | input | NUM_ANALOG | Analog blocks kept powered in deep sleep as wake sources |
| irq_pending | input | 1 | A wake-up interrupt is pending |
| osc_settle | input | CNT_W | Oscillator settle count in cycles, minus one |
| flash_ready | input | 1 | Flash has left standby and can be read |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| main_clk_en | output | 1 | Main clock gate enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock gate enables |
| osc_en | output | 1 | Internal oscillator enable |
| flash_stby | output | 1 | Flash standby request |
| analog_pwr_en | output | NUM_ANALOG | Analog block power enables |
| cur_mode | output | 2 | 00 active, 01 light sleep, 10 deep sleep, 11 waking |

## Verification
Two functions can land in the same cycle: a mode request and a wake interrupt. The bench raises `enter_req` and `irq_pending` on the same edge, for both light and deep requests. It judges the result by `cur_mode` staying at 2'b00 and `cpu_clk_en` staying high on the next cycle. A second collision is a reset that arrives during deep sleep. It is provoked between edges, and the bench checks that every enable returns to its active value before the next clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_SLEEP,
        ST_DEEP,
        ST_OSC_WAIT,
        ST_FLASH_WAIT
    } lpm_state_e;

    localparam logic [1:0] MODE_ACTIVE = 2'b00;
    localparam logic [1:0] MODE_SLEEP  = 2'b01;
    localparam logic [1:0] MODE_DEEP   = 2'b10;
    localparam logic [1:0] MODE_WAKE   = 2'b11;

endpackage

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R7: once drained, the count never wraps around unless it is reloaded
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lpm_keep_regs.sv
module lpm_keep_regs #(
    parameter int NUM_PERIPH = 8,
    parameter int NUM_ANALOG = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [NUM_PERIPH-1:0] periph_keep,
    input  logic [NUM_ANALOG-1:0] analog_keep,
    output logic [NUM_PERIPH-1:0] periph_keep_q,
    output logic [NUM_ANALOG-1:0] analog_keep_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            periph_keep_q <= '0;
            analog_keep_q <= '0;
        end else if (capture) begin
            periph_keep_q <= periph_keep;
            analog_keep_q <= analog_keep;
        end
    end

    // R3/R5: masks hold still unless a new entry is accepted
    p_masks_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(periph_keep_q) && $stable(analog_keep_q)));

endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_req,
    input  logic       req_deep,
    input  logic       irq_pending,
    input  logic       flash_ready,
    input  logic       settle_done,
    output lpm_state_e state,
    output logic       enter_acc,
    output logic       settle_load
);
    lpm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        enter_acc   = 1'b0;
        settle_load = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                if (enter_req && !irq_pending) begin
                    enter_acc = 1'b1;
                    state_d   = req_deep ? ST_DEEP : ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (irq_pending) state_d = ST_ACTIVE;
            end
            ST_DEEP: begin
                if (irq_pending) begin
                    settle_load = 1'b1;
                    state_d     = ST_OSC_WAIT;
                end
            end
            ST_OSC_WAIT: begin
                if (settle_done) state_d = ST_FLASH_WAIT;
            end
            ST_FLASH_WAIT: begin
                if (flash_ready) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    assign state = state_q;

    // R9: a request that collides with a pending wake event is dropped
    p_ignore_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && enter_req && irq_pending) |=> (state_q == ST_ACTIVE));

    // R7: a deep-sleep wake always starts with the oscillator phase
    p_deep_wake_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP && irq_pending) |=> (state_q == ST_OSC_WAIT));

    // R6: light sleep returns directly to active
    p_sleep_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && irq_pending) |=> (state_q == ST_ACTIVE));

endmodule

// File: rtl/lpm_gate_map.sv
module lpm_gate_map
    import lpm_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int NUM_ANALOG = 4
) (
    input  lpm_state_e            state,
    input  logic [NUM_PERIPH-1:0] periph_keep_q,
    input  logic [NUM_ANALOG-1:0] analog_keep_q,
    output logic                  cpu_clk_en,
    output logic                  main_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  osc_en,
    output logic                  flash_stby,
    output logic [NUM_ANALOG-1:0] analog_pwr_en,
    output logic [1:0]            cur_mode
);
    logic periph_all_on, periph_by_mask, analog_all_on;

    always_comb begin
        cpu_clk_en     = 1'b1;
        main_clk_en    = 1'b1;
        osc_en         = 1'b1;
        flash_stby     = 1'b0;
        periph_all_on  = 1'b1;
        periph_by_mask = 1'b0;
        analog_all_on  = 1'b1;
        cur_mode       = MODE_ACTIVE;
        unique case (state)
            ST_ACTIVE: begin
                cur_mode = MODE_ACTIVE;
            end
            ST_SLEEP: begin
                cpu_clk_en     = 1'b0;
                periph_all_on  = 1'b0;
                periph_by_mask = 1'b1;
                cur_mode       = MODE_SLEEP;
            end
            ST_DEEP: begin
                cpu_clk_en    = 1'b0;
                main_clk_en   = 1'b0;
                osc_en        = 1'b0;
                flash_stby    = 1'b1;
                periph_all_on = 1'b0;
                analog_all_on = 1'b0;
                cur_mode      = MODE_DEEP;
            end
            ST_OSC_WAIT: begin
                cpu_clk_en    = 1'b0;
                main_clk_en   = 1'b0;
                flash_stby    = 1'b1;
                periph_all_on = 1'b0;
                analog_all_on = 1'b0;
                cur_mode      = MODE_WAKE;
            end
            ST_FLASH_WAIT: begin
                cpu_clk_en    = 1'b0;
                periph_all_on = 1'b0;
                analog_all_on = 1'b0;
                cur_mode      = MODE_WAKE;
            end
            default: begin
                cur_mode = MODE_ACTIVE;
            end
        endcase
    end

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
        assign periph_clk_en[p] = periph_all_on | (periph_by_mask & periph_keep_q[p]);
    end

    for (genvar a = 0; a < NUM_ANALOG; a++) begin : g_analog
        assign analog_pwr_en[a] = analog_all_on | analog_keep_q[a];
    end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int NUM_ANALOG = 4,
    parameter int CNT_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enter_req,
    input  logic                  req_deep,
    input  logic [NUM_PERIPH-1:0] periph_keep,
    input  logic [NUM_ANALOG-1:0] analog_keep,
    input  logic                  irq_pending,
    input  logic [CNT_W-1:0]      osc_settle,
    input  logic                  flash_ready,
    output logic                  cpu_clk_en,
    output logic                  main_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  osc_en,
    output logic                  flash_stby,
    output logic [NUM_ANALOG-1:0] analog_pwr_en,
    output logic [1:0]            cur_mode
);
    lpm_state_e            state;
    logic                  enter_acc;
    logic                  settle_load;
    logic                  settle_done;
    logic                  in_osc_wait;
    logic [NUM_PERIPH-1:0] periph_keep_q;
    logic [NUM_ANALOG-1:0] analog_keep_q;

    assign in_osc_wait = (state == ST_OSC_WAIT);

    lpm_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_req   (enter_req),
        .req_deep    (req_deep),
        .irq_pending (irq_pending),
        .flash_ready (flash_ready),
        .settle_done (settle_done),
        .state       (state),
        .enter_acc   (enter_acc),
        .settle_load (settle_load)
    );

    lpm_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (osc_settle),
        .run      (in_osc_wait),
        .expired  (settle_done)
    );

    lpm_keep_regs #(.NUM_PERIPH(NUM_PERIPH), .NUM_ANALOG(NUM_ANALOG)) u_keep (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture       (enter_acc),
        .periph_keep   (periph_keep),
        .analog_keep   (analog_keep),
        .periph_keep_q (periph_keep_q),
        .analog_keep_q (analog_keep_q)
    );

    lpm_gate_map #(.NUM_PERIPH(NUM_PERIPH), .NUM_ANALOG(NUM_ANALOG)) u_map (
        .state         (state),
        .periph_keep_q (periph_keep_q),
        .analog_keep_q (analog_keep_q),
        .cpu_clk_en    (cpu_clk_en),
        .main_clk_en   (main_clk_en),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en),
        .flash_stby    (flash_stby),
        .analog_pwr_en (analog_pwr_en),
        .cur_mode      (cur_mode)
    );

    // R4: the flash is never in standby while the main clock runs
    p_stby_main_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flash_stby |-> !main_clk_en);

    // R7: the oscillator comes back before the main clock
    p_osc_before_main_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> !main_clk_en);

    // R8: the processor clock ends a wake only after flash ready was seen
    p_cpu_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk_en) && $past(cur_mode) == MODE_WAKE) |-> $past(flash_ready));

    // R3: peripheral gating is steady for the whole of a light sleep
    p_sleep_periph_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SLEEP && $past(cur_mode) == MODE_SLEEP) |-> $stable(periph_clk_en));

endmodule

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;
    localparam int NP = 4;
    localparam int NA = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enter_req, req_deep, irq_pending, flash_ready;
    logic [NP-1:0] periph_keep;
    logic [NA-1:0] analog_keep;
    logic [CW-1:0] osc_settle;
    logic          cpu_clk_en, main_clk_en, osc_en, flash_stby;
    logic [NP-1:0] periph_clk_en;
    logic [NA-1:0] analog_pwr_en;
    logic [1:0]    cur_mode;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lpm_clk_ctrl #(.NUM_PERIPH(NP), .NUM_ANALOG(NA), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .req_deep(req_deep),
        .periph_keep(periph_keep), .analog_keep(analog_keep),
        .irq_pending(irq_pending), .osc_settle(osc_settle),
        .flash_ready(flash_ready), .cpu_clk_en(cpu_clk_en),
        .main_clk_en(main_clk_en), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .flash_stby(flash_stby),
        .analog_pwr_en(analog_pwr_en), .cur_mode(cur_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // all-on snapshot packed as {cpu, main, periph, osc, stby, analog, mode}
    function automatic logic [31:0] snap();
        return {19'd0, cpu_clk_en, main_clk_en, periph_clk_en, osc_en, flash_stby,
                analog_pwr_en, cur_mode};
    endfunction

    function automatic logic [31:0] expect_vec(logic c, logic m, logic [NP-1:0] p, logic o,
                                               logic s, logic [NA-1:0] a, logic [1:0] md);
        return {19'd0, c, m, p, o, s, a, md};
    endfunction

    task automatic enter(input logic deep, input logic [NP-1:0] pk, input logic [NA-1:0] ak);
        @(negedge clk);
        enter_req   = 1'b1;
        req_deep    = deep;
        periph_keep = pk;
        analog_keep = ak;
        @(negedge clk);
        enter_req   = 1'b0;
        periph_keep = ~pk;
        analog_keep = ~ak;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; enter_req = 1'b0; req_deep = 1'b0; irq_pending = 1'b0;
        flash_ready = 1'b0; periph_keep = '0; analog_keep = '0; osc_settle = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active after reset", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));

        // light sleep sweep over every keep mask
        for (int pk = 0; pk < (1 << NP); pk++) begin
            enter(1'b0, NP'(pk), NA'(pk));
            chk("R2 R3 sleep outputs", snap(),
                expect_vec(0, 1, NP'(pk), 1, 0, '1, 2'b01));
            @(negedge clk);
            chk("R3 sleep holds", snap(), expect_vec(0, 1, NP'(pk), 1, 0, '1, 2'b01));
            irq_pending = 1'b1;
            @(negedge clk);
            irq_pending = 1'b0;
            chk("R6 sleep exit", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));
        end

        // collisions of request and pending interrupt
        for (int d = 0; d < 2; d++) begin
            @(negedge clk);
            enter_req = 1'b1; req_deep = d[0]; irq_pending = 1'b1;
            @(negedge clk);
            enter_req = 1'b0; irq_pending = 1'b0;
            chk("R9 request ignored", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));
            @(negedge clk);
            chk("R9 still active", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));
        end

        // deep sleep sweep over analog masks and settle counts
        for (int ak = 0; ak < (1 << NA); ak++) begin
            for (int s = 0; s < 4; s++) begin
                int k;
                int lim;
                lim = s * 2 + ak % 2;
                enter(1'b1, '1, NA'(ak));
                chk("R2 R4 R5 deep outputs", snap(),
                    expect_vec(0, 0, '0, 0, 1, NA'(ak), 2'b10));
                osc_settle  = CW'(lim);
                irq_pending = 1'b1;
                @(negedge clk);
                irq_pending = 1'b0;
                osc_settle  = '0;
                chk("R7 osc on main gated", snap(),
                    expect_vec(0, 0, '0, 1, 1, NA'(ak), 2'b11));
                k = 0;
                while (!main_clk_en && k < 40) begin
                    @(negedge clk);
                    k++;
                    if (!main_clk_en)
                        chk("R5 analog in wake", 32'(analog_pwr_en), 32'(ak));
                end
                chk("R7 settle length", 32'(k), 32'(lim + 1));
                chk("R7 flash released", snap(),
                    expect_vec(0, 1, '0, 1, 0, NA'(ak), 2'b11));
                repeat (2) @(negedge clk);
                chk("R8 cpu waits ready", 32'(cpu_clk_en), 32'd0);
                flash_ready = 1'b1;
                @(negedge clk);
                flash_ready = 1'b0;
                chk("R8 cpu after ready", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));
            end
        end

        // reset landing during deep sleep
        enter(1'b1, '0, 3'b010);
        chk("R4 deep before reset", 32'(osc_en), 32'd0);
        #3 rst_n = 1'b0;
        #1 chk("R1 reset in deep", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active after deep reset", snap(), expect_vec(1, 1, '1, 1, 0, '1, 2'b00));

        report();
        $finish;
    end
endmodule